// File: doc/BRIEF.md
# Multi-Digit BCD Seven-Segment Decoder with Zero Suppression

The block turns a row of BCD digits into active-LOW drive patterns for seven-segment displays. Each digit decoder has a blank input, a lamp-test input, a ripple-blank input and a ripple-blank output. A wrapper connects these into two ripple chains. On the integer side the chain runs from the most significant digit toward the units digit and removes leading zeros. On the fractional side the chain runs from the rightmost digit toward the decimal point and removes trailing zeros. A zero that has a nonzero digit on its display-ward side stays lit. The units digit always shows its value, so a value of zero still displays one "0".

The decode and the ripple chains are combinational. One register stage holds the whole segment vector, so every output follows its inputs one clock later. Digit k occupies `bcd_in[4k+3:4k]` and `seg_n[7k+6:7k]`. Digit 0 is the rightmost digit. The units digit is at index `FRAC_DIGITS`.

Top module: `seg_display_top`

## Requirements
- R1: A lit digit with code 0 to 9 drives the standard shape, active LOW. Segment bit order inside a digit is bit0=a, bit1=b, bit2=c, bit3=d, bit4=e, bit5=f, bit6=g. The shapes are: 6 includes the top bar a, 7 uses a,b,c, and 9 includes the bottom bar d.
- R2: Codes 10 to 15 turn all seven segments of the digit off (7'h7F), unless lamp test is active.
- R3: When `blank_n[k]` is LOW, digit k is all off, whatever its code, the lamp test and the ripple input.
- R4: When `lamp_test_n` is LOW, every digit whose `blank_n` is HIGH turns all segments on (7'h00), whatever its code and ripple state.
- R5: With `lead_sup_n` LOW, an integer digit above the units digit is off when its code is 0 and every more significant integer digit is also suppressed. With `lead_sup_n` HIGH, leading zeros are shown.
- R6: The units digit never takes part in ripple blanking. A zero there is displayed.
- R7: With `trail_sup_n` LOW, a fractional digit is off when its code is 0 and every fractional digit to its right is also suppressed. With `trail_sup_n` HIGH, trailing zeros are shown.
- R8: A digit forced off by its `blank_n` passes "still blanking" on to the next digit in its chain, in the same way as a suppressed zero.
- R9: A zero lit by lamp test ends its ripple chain. Once lamp test is released, zero suppression returns.
- R10: Outputs are registered. A change on any input appears at `seg_n` one clock later. While `rst_n` is LOW, all segments are off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active LOW |
| bcd_in | input | 4*(INT_DIGITS+FRAC_DIGITS) | Packed BCD digits, digit 0 rightmost |
| blank_n | input | INT_DIGITS+FRAC_DIGITS | Per-digit forced blank, active LOW |
| lamp_test_n | input | 1 | Light all segments, active LOW |
| lead_sup_n | input | 1 | Enable leading-zero suppression, active LOW |
| trail_sup_n | input | 1 | Enable trailing-zero suppression, active LOW |
| seg_n | output | 7*(INT_DIGITS+FRAC_DIGITS) | Registered segment drives, active LOW |

## Verification
The hardest case to reach is a long ripple run across several digits. In a run, one digit is forced blank and its neighbours are zeros that must then disappear. A lamp test arriving in the middle of such a run must cut it off. Uniform random codes almost never produce runs of zeros. The stimulus therefore makes each digit zero half the time and applies blanks and lamp test at low rates. A bench model walks both chains digit by digit, so every combination it meets is checked. Directed patterns cover an all-zero value, an embedded zero, and a lamp test over a suppressed zero.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int BCD_W = 4;
    localparam int SEG_W = 7;

    localparam logic [SEG_W-1:0] SEG_ALL_OFF = '1;
    localparam logic [SEG_W-1:0] SEG_ALL_ON  = '0;

    // lit segments, active HIGH, bit0 = a ... bit6 = g
    function automatic logic [SEG_W-1:0] shape_of(input logic [BCD_W-1:0] code);
        logic [SEG_W-1:0] s;
        case (code)
            4'd0:    s = 7'b0111111;
            4'd1:    s = 7'b0000110;
            4'd2:    s = 7'b1011011;
            4'd3:    s = 7'b1001111;
            4'd4:    s = 7'b1100110;
            4'd5:    s = 7'b1101101;
            4'd6:    s = 7'b1111101;
            4'd7:    s = 7'b0000111;
            4'd8:    s = 7'b1111111;
            4'd9:    s = 7'b1101111;
            default: s = 7'b0000000;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/seg_digit_dec.sv
module seg_digit_dec
    import seg_pkg::*;
(
    input  logic [BCD_W-1:0] code,
    input  logic             blank_n,
    input  logic             lamp_n,
    input  logic             rip_in_n,
    output logic [SEG_W-1:0] seg_n,
    output logic             rip_out_n
);

    logic is_zero;
    logic zero_drop;

    always_comb begin
        is_zero   = (code == '0);
        zero_drop = !rip_in_n && is_zero && lamp_n;

        if (!blank_n) begin
            seg_n = SEG_ALL_OFF;
        end else if (!lamp_n) begin
            seg_n = SEG_ALL_ON;
        end else if (zero_drop) begin
            seg_n = SEG_ALL_OFF;
        end else begin
            seg_n = ~shape_of(code);
        end

        rip_out_n = blank_n && !zero_drop;
    end

endmodule

// File: rtl/seg_ripple_chain.sv
module seg_ripple_chain
    import seg_pkg::*;
#(
    parameter int INT_DIGITS  = 4,
    parameter int FRAC_DIGITS = 2,
    localparam int NDIG       = INT_DIGITS + FRAC_DIGITS,
    localparam int UNITS      = FRAC_DIGITS
) (
    input  logic [BCD_W*NDIG-1:0] bcd_in,
    input  logic [NDIG-1:0]       blank_n,
    input  logic                  lamp_test_n,
    input  logic                  lead_sup_n,
    input  logic                  trail_sup_n,
    output logic [SEG_W*NDIG-1:0] seg_n
);

    for (genvar k = 0; k < NDIG; k++) begin : g_dig
        logic rbi_w;
        logic rbo_w;

        if (k == UNITS) begin : g_units
            assign rbi_w = 1'b1;
        end else if (k > UNITS) begin : g_int
            if (k == NDIG - 1) begin : g_top
                assign rbi_w = lead_sup_n;
            end else begin : g_mid
                assign rbi_w = g_dig[k+1].rbo_w;
            end
        end else begin : g_frac
            if (k == 0) begin : g_right
                assign rbi_w = trail_sup_n;
            end else begin : g_mid
                assign rbi_w = g_dig[k-1].rbo_w;
            end
        end

        seg_digit_dec u_dec (
            .code      (bcd_in[BCD_W*k +: BCD_W]),
            .blank_n   (blank_n[k]),
            .lamp_n    (lamp_test_n),
            .rip_in_n  (rbi_w),
            .seg_n     (seg_n[SEG_W*k +: SEG_W]),
            .rip_out_n (rbo_w)
        );
    end

endmodule

// File: rtl/seg_display_top.sv
module seg_display_top
    import seg_pkg::*;
#(
    parameter int INT_DIGITS  = 4,
    parameter int FRAC_DIGITS = 2,
    localparam int NDIG       = INT_DIGITS + FRAC_DIGITS,
    localparam int SEG_BITS   = SEG_W * NDIG
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BCD_W*NDIG-1:0] bcd_in,
    input  logic [NDIG-1:0]       blank_n,
    input  logic                  lamp_test_n,
    input  logic                  lead_sup_n,
    input  logic                  trail_sup_n,
    output logic [SEG_BITS-1:0]   seg_n
);

    typedef struct packed {
        logic [SEG_BITS-1:0] seg;
    } disp_state_t;

    disp_state_t         state_d, state_q;
    logic [SEG_BITS-1:0] chain_seg_n;

    seg_ripple_chain #(
        .INT_DIGITS  (INT_DIGITS),
        .FRAC_DIGITS (FRAC_DIGITS)
    ) u_chain (
        .bcd_in      (bcd_in),
        .blank_n     (blank_n),
        .lamp_test_n (lamp_test_n),
        .lead_sup_n  (lead_sup_n),
        .trail_sup_n (trail_sup_n),
        .seg_n       (chain_seg_n)
    );

    always_comb begin
        state_d     = state_q;
        state_d.seg = chain_seg_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.seg <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign seg_n = state_q.seg;

endmodule

// File: rtl/seg_display_chk.sv
module seg_display_chk
    import seg_pkg::*;
#(
    parameter int INT_DIGITS  = 4,
    parameter int FRAC_DIGITS = 2,
    localparam int NDIG       = INT_DIGITS + FRAC_DIGITS,
    localparam int UNITS      = FRAC_DIGITS
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [BCD_W*NDIG-1:0] bcd_in,
    input logic [NDIG-1:0]       blank_n,
    input logic                  lamp_test_n,
    input logic [SEG_W*NDIG-1:0] seg_n
);

    assert_lamp_all_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lamp_test_n && (&blank_n)) |=> (seg_n == '0));

    assert_all_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n == '0) |=> (seg_n == '1));

    assert_units_shown_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_test_n && blank_n[UNITS] && (bcd_in[BCD_W*UNITS +: BCD_W] < 4'd10))
        |=> (seg_n[SEG_W*UNITS +: SEG_W] != '1));

    for (genvar k = 0; k < NDIG; k++) begin : g_chk
        assert_digit_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !blank_n[k] |=> (seg_n[SEG_W*k +: SEG_W] == '1));

        assert_bad_code_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (lamp_test_n && (bcd_in[BCD_W*k +: BCD_W] > 4'd9))
            |=> (seg_n[SEG_W*k +: SEG_W] == '1));

        assert_eight_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (lamp_test_n && blank_n[k] && (bcd_in[BCD_W*k +: BCD_W] == 4'd8))
            |=> (seg_n[SEG_W*k +: SEG_W] == '0));
    end

endmodule

bind seg_display_top seg_display_chk #(
    .INT_DIGITS  (INT_DIGITS),
    .FRAC_DIGITS (FRAC_DIGITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bcd_in      (bcd_in),
    .blank_n     (blank_n),
    .lamp_test_n (lamp_test_n),
    .seg_n       (seg_n)
);

// File: tb/seg_display_top_test.sv
module seg_display_top_test;

    localparam int INTD = 4;
    localparam int FRD  = 2;
    localparam int N    = INTD + FRD;
    localparam int UNIT = FRD;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [4*N-1:0] bcd_in = '0;
    logic [N-1:0]   blank_n = '1;
    logic           lamp_test_n = 1'b1;
    logic           lead_sup_n = 1'b1;
    logic           trail_sup_n = 1'b1;
    logic [7*N-1:0] seg_n;

    int checks = 0;
    int errors = 0;
    logic [6:0] exp_seg [N];
    string      exp_tag [N];

    always #4 clk = ~clk;

    seg_display_top #(.INT_DIGITS(INTD), .FRAC_DIGITS(FRD)) uut (
        .clk(clk), .rst_n(rst_n), .bcd_in(bcd_in), .blank_n(blank_n),
        .lamp_test_n(lamp_test_n), .lead_sup_n(lead_sup_n),
        .trail_sup_n(trail_sup_n), .seg_n(seg_n)
    );

    // active-LOW expected shapes, bit0 = a
    function automatic logic [6:0] glyph(input int v);
        case (v)
            0: return ~7'h3F;  1: return ~7'h06;  2: return ~7'h5B;
            3: return ~7'h4F;  4: return ~7'h66;  5: return ~7'h6D;
            6: return ~7'h7D;  7: return ~7'h07;  8: return ~7'h7F;
            9: return ~7'h6F;
            default: return 7'h7F;
        endcase
    endfunction

    function automatic logic one_digit(input int k, input logic rbi,
                                       output logic [6:0] s, output string t);
        int d = int'(bcd_in[4*k +: 4]);
        if (!blank_n[k]) begin
            s = 7'h7F; t = "R3/R8"; return 1'b0;
        end
        if (!lamp_test_n) begin
            s = 7'h00; t = "R4/R9"; return 1'b1;
        end
        if (!rbi && d == 0) begin
            s = 7'h7F; t = (k > UNIT) ? "R5" : "R7"; return 1'b0;
        end
        s = glyph(d);
        t = (d > 9) ? "R2" : ((k == UNIT) ? "R6" : "R1");
        return 1'b1;
    endfunction

    task automatic compute_expected();
        logic rip;
        rip = lead_sup_n;
        for (int k = N - 1; k >= UNIT; k--)
            rip = one_digit(k, (k == UNIT) ? 1'b1 : rip, exp_seg[k], exp_tag[k]);
        rip = trail_sup_n;
        for (int k = 0; k < UNIT; k++)
            rip = one_digit(k, rip, exp_seg[k], exp_tag[k]);
    endtask

    task automatic step_and_check(input string what);
        compute_expected();
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < N; k++) begin
            checks++;
            if (seg_n[7*k +: 7] !== exp_seg[k]) begin
                errors++;
                $display("FAIL %s %s digit %0d: actual %b expected %b",
                         exp_tag[k], what, k, seg_n[7*k +: 7], exp_seg[k]);
            end
        end
    endtask

    function automatic logic [4*N-1:0] pack6(input int d5, d4, d3, d2, d1, d0);
        return {4'(d5), 4'(d4), 4'(d3), 4'(d2), 4'(d1), 4'(d0)};
    endfunction

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R10: reset holds all segments off
        bcd_in = pack6(8, 8, 8, 8, 8, 8);
        repeat (3) @(negedge clk);
        checks++;
        if (seg_n !== '1) begin
            errors++;
            $display("FAIL R10 reset: actual %h expected all ones", seg_n);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R6 R7: all zero value shows only the units zero
        lead_sup_n = 1'b0; trail_sup_n = 1'b0;
        bcd_in = pack6(0, 0, 0, 0, 0, 0);
        step_and_check("all zero");

        // R5 R7: 0102.50, embedded zero kept, leading and trailing dropped
        bcd_in = pack6(0, 1, 0, 2, 5, 0);
        step_and_check("embedded zero");

        // R10: one clock of latency, old value still present before the edge
        bcd_in = pack6(9, 9, 9, 9, 9, 9);
        #1;
        checks++;
        if (seg_n[7*UNIT +: 7] !== glyph(2)) begin
            errors++;
            $display("FAIL R10 latency: actual %b expected %b", seg_n[7*UNIT +: 7], glyph(2));
        end
        step_and_check("all nines R1");

        // R5 R7 disabled: zeros displayed
        lead_sup_n = 1'b1; trail_sup_n = 1'b1;
        bcd_in = pack6(0, 0, 3, 7, 0, 0);
        step_and_check("suppression off");

        // R2: invalid codes off
        lead_sup_n = 1'b0; trail_sup_n = 1'b0;
        bcd_in = pack6(10, 11, 12, 13, 14, 15);
        step_and_check("invalid codes");

        // R8: blanked nonzero top digit lets next zero disappear
        bcd_in = pack6(4, 0, 6, 1, 0, 0);
        blank_n = 6'b011111;
        step_and_check("blank ripples");

        // R9: lamp test over suppressed zeros, then release
        bcd_in = pack6(0, 0, 0, 0, 0, 0);
        blank_n = '1; lamp_test_n = 1'b0;
        step_and_check("lamp test");
        lamp_test_n = 1'b1;
        step_and_check("lamp released");

        // R3: blank beats lamp test
        lamp_test_n = 1'b0; blank_n = 6'b101010;
        step_and_check("blank over lamp");
        lamp_test_n = 1'b1; blank_n = '1;

        for (int i = 0; i < 400; i++) begin
            for (int k = 0; k < N; k++)
                bcd_in[4*k +: 4] = (($urandom % 2) == 0) ? 4'd0 : 4'($urandom % 16);
            for (int k = 0; k < N; k++)
                blank_n[k] = (($urandom % 12) != 0);
            lamp_test_n = (($urandom % 10) != 0);
            lead_sup_n  = 1'($urandom % 2);
            trail_sup_n = 1'($urandom % 2);
            step_and_check("random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule